// File: doc/BRIEF.md
# Sticky Bus Parity Error Logger

This block sits beside a bus interface and keeps a diagnostic record of parity and ECC trouble. When the interface is the target of a data transfer and its datapath flags a data error, the block captures the data bus value in a 64-bit log. It also records whether the error was correctable. The capture is first-error only. After one load the log is frozen until software writes 1 to the log-valid flag. That write arms the log again for the next error.

Two single-bit phase logs run in parallel. One records the attribute-phase parity, and one records the parity of the upper half of a dual address cycle. Each loads only when its own sticky status bit is clear, and writing 1 to that status bit clears both the status bit and the logged parity. All logged state is kept through the ordinary functional reset and is cleared only by the power-on reset. Software reaches everything through a small register port with word addresses and a registered read.

Top module: `buserr_log`

## Requirements
- R1: When `ev_data_err` is high while log-valid (CTRL bit 0) is clear, the next edge loads the data value, sets log-valid to 1 and stores the correctable flag. Bits 31:0 of the data are read at address 0.
- R2: On a load with `ev_data_wide` = 1, all 64 bits load, and bits 63:32 are read at address 1. With `ev_data_wide` = 0 (a 32-bit transfer), only bits 31:0 load and bits 63:32 keep their previous contents.
- R3: While log-valid is set, further data errors change neither the data log nor the correctable flag.
- R4: A write to address 3 with bit 0 = 1 clears log-valid and arms the log again. A write with bit 0 = 0 leaves log-valid unchanged.
- R5: MISC (address 2) bit 18 reads 1 when the logged data error was correctable (`ev_data_corr` = 1) and 0 when it was uncorrectable. It loads only together with the data log.
- R6: An attribute-phase error (`ev_attr_err`) with CTRL bit 1 clear sets CTRL bit 1 and loads MISC bit 17 with `ev_attr_par`.
- R7: An address-phase error (`ev_addr_err`) with CTRL bit 2 clear sets CTRL bit 2 and loads MISC bit 16. The loaded value is `ev_addr_hi_par` for a dual address cycle (`ev_addr_dac` = 1) and 0 for a single address cycle.
- R8: While CTRL bit 1 or bit 2 is set, later errors of that kind leave its MISC bit unchanged. Writing 1 to the status bit at address 3 clears both the status bit and its MISC bit to 0.
- R9: Reserved bits read as 0: MISC bits 31:19 and 15:0, and CTRL bits 31:3. Writes to addresses 0, 1 and 2 have no effect.
- R10: When an error event arrives in the same cycle as the write-1 clear of its flag, the clear wins and the event is not logged.
- R11: `por_n` low sets every log and status bit to 0. `rst_n` low clears only `reg_rdata` and leaves all logged state intact.
- R12: `reg_rdata` shows the register selected by `reg_addr` on the clock edge where `reg_rd` is high, and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears sticky state |
| rst_n | input | 1 | Functional reset, active low, clears read data only |
| ev_data_err | input | 1 | Target data parity/ECC error detected |
| ev_data_corr | input | 1 | 1 = the data error is correctable |
| ev_data_wide | input | 1 | 1 = 64-bit transfer, 0 = 32-bit transfer |
| ev_data_val | input | 64 | Data bus value of the failing transfer |
| ev_attr_err | input | 1 | Attribute-phase parity error |
| ev_attr_par | input | 1 | Attribute-phase parity, driven or captured |
| ev_addr_err | input | 1 | Address-phase parity error |
| ev_addr_dac | input | 1 | 1 = dual address cycle |
| ev_addr_hi_par | input | 1 | Parity of the upper address phase |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Word address: 0/1 data log, 2 MISC, 3 CTRL |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |

## Verification
The bench builds the block with its default values: a 64-bit data log read through two 32-bit slices, and 2-bit addresses. These values cover half-width loads, where the upper slice has to keep stale data, and they put all four registers in a range that random addresses hit often. Random error events, with write-1 clears landing at random times, create collisions between clears and events and repeated errors against frozen logs. Directed steps then cover single versus dual address cycles and a functional reset in the middle of a run.

// File: rtl/buserr_pkg.sv
package buserr_pkg;
  // Bit positions within the MISC word (read by software decoders)
  localparam int MISC_CORR_BIT = 18;
  localparam int MISC_ATTR_BIT = 17;
  localparam int MISC_ADDR_BIT = 16;
  // Bit positions within the CTRL word
  localparam int CTRL_VALID_BIT = 0;
  localparam int CTRL_ATTR_BIT  = 1;
  localparam int CTRL_ADDR_BIT  = 2;
  localparam int CTRL_USED_W    = 3;
  // Phase log slots
  localparam int NPHASE  = 2;
  localparam int PH_ATTR = 0;
  localparam int PH_ADDR = 1;
endpackage

// File: rtl/buserr_dlog.sv
module buserr_dlog #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              ev_err,
  input  logic              ev_corr,
  input  logic              ev_wide,
  input  logic [DATA_W-1:0] ev_data,
  input  logic              clr_valid,
  output logic              log_valid,
  output logic [DATA_W-1:0] dlog,
  output logic              corr
);
  localparam int HALF_W = DATA_W / 2;

  logic              load;
  logic              valid_d;
  logic [HALF_W-1:0] lo_q, hi_q;
  logic              corr_q, valid_q;

  // clear beats a same-cycle event
  always_comb begin
    load    = ev_err && !valid_q && !clr_valid;
    valid_d = valid_q;
    if (clr_valid)
      valid_d = 1'b0;
    else if (load)
      valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      valid_q <= 1'b0;
    else
      valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      lo_q   <= '0;
      corr_q <= 1'b0;
    end else if (load) begin
      lo_q   <= ev_data[HALF_W-1:0];
      corr_q <= ev_corr;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      hi_q <= '0;
    else if (load && ev_wide)
      hi_q <= ev_data[DATA_W-1:HALF_W];
  end

  assign log_valid = valid_q;
  assign dlog      = {hi_q, lo_q};
  assign corr      = corr_q;
endmodule

// File: rtl/buserr_plog.sv
module buserr_plog (
  input  logic clk,
  input  logic por_n,
  input  logic ev_err,
  input  logic ev_par,
  input  logic clr_sts,
  output logic sts,
  output logic par
);
  logic load;
  logic sts_d, par_d, sts_q, par_q;

  always_comb begin
    load  = ev_err && !sts_q && !clr_sts;
    sts_d = sts_q;
    par_d = par_q;
    if (clr_sts) begin
      sts_d = 1'b0;
      par_d = 1'b0;
    end else if (load) begin
      sts_d = 1'b1;
      par_d = ev_par;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sts_q <= 1'b0;
      par_q <= 1'b0;
    end else begin
      sts_q <= sts_d;
      par_q <= par_d;
    end
  end

  assign sts = sts_q;
  assign par = par_q;
endmodule

// File: rtl/buserr_regif.sv
module buserr_regif
  import buserr_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int REG_W  = 32,
  parameter int ADDR_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr,
  input  logic                   reg_rd,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic [CTRL_USED_W-1:0] wbits,
  input  logic [DATA_W-1:0]      dlog,
  input  logic                   log_valid,
  input  logic                   corr,
  input  logic [NPHASE-1:0]      phase_sts,
  input  logic [NPHASE-1:0]      phase_par,
  output logic                   clr_valid,
  output logic [NPHASE-1:0]      clr_phase,
  output logic [REG_W-1:0]       reg_rdata
);
  localparam int NSLICE = DATA_W / REG_W;
  localparam logic [ADDR_W-1:0] A_MISC = ADDR_W'(NSLICE);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(NSLICE + 1);

  logic [REG_W-1:0] slice [NSLICE];
  logic [REG_W-1:0] rd_mux;
  logic             ctrl_wr;

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    assign slice[s] = dlog[s*REG_W +: REG_W];
  end

  always_comb begin
    ctrl_wr              = reg_wr && (reg_addr == A_CTRL);
    clr_valid            = ctrl_wr && wbits[CTRL_VALID_BIT];
    clr_phase[PH_ATTR]   = ctrl_wr && wbits[CTRL_ATTR_BIT];
    clr_phase[PH_ADDR]   = ctrl_wr && wbits[CTRL_ADDR_BIT];
  end

  always_comb begin
    rd_mux = '0;
    for (int s = 0; s < NSLICE; s++)
      if (reg_addr == ADDR_W'(s))
        rd_mux = slice[s];
    if (reg_addr == A_MISC) begin
      rd_mux[MISC_CORR_BIT] = corr;
      rd_mux[MISC_ATTR_BIT] = phase_par[PH_ATTR];
      rd_mux[MISC_ADDR_BIT] = phase_par[PH_ADDR];
    end
    if (reg_addr == A_CTRL) begin
      rd_mux[CTRL_VALID_BIT] = log_valid;
      rd_mux[CTRL_ATTR_BIT]  = phase_sts[PH_ATTR];
      rd_mux[CTRL_ADDR_BIT]  = phase_sts[PH_ADDR];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      reg_rdata <= '0;
    else if (reg_rd)
      reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/buserr_log.sv
module buserr_log
  import buserr_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int REG_W  = 32,
  parameter int ADDR_W = $clog2(DATA_W / REG_W + 2)
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              ev_data_err,
  input  logic              ev_data_corr,
  input  logic              ev_data_wide,
  input  logic [DATA_W-1:0] ev_data_val,
  input  logic              ev_attr_err,
  input  logic              ev_attr_par,
  input  logic              ev_addr_err,
  input  logic              ev_addr_dac,
  input  logic              ev_addr_hi_par,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata
);
  logic              log_valid;
  logic [DATA_W-1:0] dlog;
  logic              corr;
  logic              clr_valid;
  logic [NPHASE-1:0] clr_phase;
  logic [NPHASE-1:0] phase_err, phase_val, phase_sts, phase_par;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata[REG_W-1:CTRL_USED_W];

  // single address cycles log a forced zero
  assign phase_err[PH_ATTR] = ev_attr_err;
  assign phase_val[PH_ATTR] = ev_attr_par;
  assign phase_err[PH_ADDR] = ev_addr_err;
  assign phase_val[PH_ADDR] = ev_addr_dac & ev_addr_hi_par;

  buserr_dlog #(.DATA_W(DATA_W)) dlog_i (
    .clk       (clk),
    .por_n     (por_n),
    .ev_err    (ev_data_err),
    .ev_corr   (ev_data_corr),
    .ev_wide   (ev_data_wide),
    .ev_data   (ev_data_val),
    .clr_valid (clr_valid),
    .log_valid (log_valid),
    .dlog      (dlog),
    .corr      (corr)
  );

  for (genvar p = 0; p < NPHASE; p++) begin : g_phase
    buserr_plog plog_i (
      .clk     (clk),
      .por_n   (por_n),
      .ev_err  (phase_err[p]),
      .ev_par  (phase_val[p]),
      .clr_sts (clr_phase[p]),
      .sts     (phase_sts[p]),
      .par     (phase_par[p])
    );
  end

  buserr_regif #(.DATA_W(DATA_W), .REG_W(REG_W), .ADDR_W(ADDR_W)) regif_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .wbits     (reg_wdata[CTRL_USED_W-1:0]),
    .dlog      (dlog),
    .log_valid (log_valid),
    .corr      (corr),
    .phase_sts (phase_sts),
    .phase_par (phase_par),
    .clr_valid (clr_valid),
    .clr_phase (clr_phase),
    .reg_rdata (reg_rdata)
  );
endmodule

// File: rtl/buserr_log_chk.sv
module buserr_log_chk #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              por_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [2:0]        wbits,
  input logic              ev_data_err,
  input logic              ev_data_corr,
  input logic              ev_data_wide,
  input logic [DATA_W/2-1:0] ev_data_lo,
  input logic              ev_attr_err,
  input logic              ev_addr_err,
  input logic              ev_addr_dac,
  input logic              log_valid,
  input logic [DATA_W-1:0] dlog,
  input logic              corr,
  input logic [1:0]        phase_sts,
  input logic [1:0]        phase_par
);
  localparam int HALF_W = DATA_W / 2;
  localparam logic [ADDR_W-1:0] A_CTRL = {ADDR_W{1'b1}};

  logic wr_ctrl, clr_v, clr_a, clr_d, ld;
  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign clr_v   = wr_ctrl && wbits[0];
  assign clr_a   = wr_ctrl && wbits[1];
  assign clr_d   = wr_ctrl && wbits[2];
  assign ld      = ev_data_err && !log_valid && !clr_v;

  p_load_r1: assert property (@(posedge clk) disable iff (!por_n)
    ld |=> log_valid && dlog[HALF_W-1:0] == $past(ev_data_lo));
  p_corr_r5: assert property (@(posedge clk) disable iff (!por_n)
    ld |=> corr == $past(ev_data_corr));
  p_half_keep_r2: assert property (@(posedge clk) disable iff (!por_n)
    ld && !ev_data_wide |=> $stable(dlog[DATA_W-1:HALF_W]));
  p_freeze_r3: assert property (@(posedge clk) disable iff (!por_n)
    log_valid && !clr_v |=> log_valid && $stable(dlog) && $stable(corr));
  p_clr_wins_r10: assert property (@(posedge clk) disable iff (!por_n)
    clr_v |=> !log_valid);
  p_attr_set_r6: assert property (@(posedge clk) disable iff (!por_n)
    ev_attr_err && !clr_a |=> phase_sts[0]);
  p_addr_sac_r7: assert property (@(posedge clk) disable iff (!por_n)
    ev_addr_err && !phase_sts[1] && !clr_d && !ev_addr_dac |=> phase_sts[1] && !phase_par[1]);
  p_first_kept_r8: assert property (@(posedge clk) disable iff (!por_n)
    phase_sts[0] && !clr_a |=> phase_sts[0] && $stable(phase_par[0]));
  p_clear_par_r8: assert property (@(posedge clk) disable iff (!por_n)
    clr_d |=> !phase_sts[1] && !phase_par[1]);
endmodule

bind buserr_log buserr_log_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk          (clk),
  .por_n        (por_n),
  .reg_wr       (reg_wr),
  .reg_addr     (reg_addr),
  .wbits        (reg_wdata[2:0]),
  .ev_data_err  (ev_data_err),
  .ev_data_corr (ev_data_corr),
  .ev_data_wide (ev_data_wide),
  .ev_data_lo   (ev_data_val[DATA_W/2-1:0]),
  .ev_attr_err  (ev_attr_err),
  .ev_addr_err  (ev_addr_err),
  .ev_addr_dac  (ev_addr_dac),
  .log_valid    (log_valid),
  .dlog         (dlog),
  .corr         (corr),
  .phase_sts    (phase_sts),
  .phase_par    (phase_par)
);

// File: tb/buserr_log_tb.sv
`timescale 1ns/1ps
module buserr_log_tb_top;
  logic        clk = 1'b0;
  logic        por_n, rst_n;
  logic        ev_data_err, ev_data_corr, ev_data_wide;
  logic [63:0] ev_data_val;
  logic        ev_attr_err, ev_attr_par, ev_addr_err, ev_addr_dac, ev_addr_hi_par;
  logic        reg_wr, reg_rd;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  // model
  logic [63:0] m_dlog;
  logic        m_valid, m_corr, m_apar, m_asts, m_dpar, m_dsts;

  always #4 clk = ~clk;

  buserr_log dut_i (.*);

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL R12 watchdog actual=%0d expected<=100000", cyc);
      summary();
    end
  end

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic idle();
    ev_data_err = 0; ev_data_corr = 0; ev_data_wide = 0; ev_data_val = '0;
    ev_attr_err = 0; ev_attr_par = 0; ev_addr_err = 0; ev_addr_dac = 0;
    ev_addr_hi_par = 0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
  endtask

  task automatic model_zero();
    m_dlog = '0; m_valid = 0; m_corr = 0; m_apar = 0; m_asts = 0; m_dpar = 0; m_dsts = 0;
  endtask

  // advance one clock; model follows the requirements
  task automatic tick();
    logic cv, ca, cd;
    cv = reg_wr && reg_addr == 2'd3 && reg_wdata[0];
    ca = reg_wr && reg_addr == 2'd3 && reg_wdata[1];
    cd = reg_wr && reg_addr == 2'd3 && reg_wdata[2];
    if (por_n) begin
      if (cv) m_valid = 0;                        // R10: clear wins
      else if (ev_data_err && !m_valid) begin     // R1, R2, R5
        m_dlog[31:0] = ev_data_val[31:0];
        if (ev_data_wide) m_dlog[63:32] = ev_data_val[63:32];
        m_corr = ev_data_corr;
        m_valid = 1;
      end
      if (ca) begin m_asts = 0; m_apar = 0; end    // R8
      else if (ev_attr_err && !m_asts) begin m_asts = 1; m_apar = ev_attr_par; end
      if (cd) begin m_dsts = 0; m_dpar = 0; end
      else if (ev_addr_err && !m_dsts) begin m_dsts = 1; m_dpar = ev_addr_dac & ev_addr_hi_par; end
    end
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  function automatic logic [31:0] exp_reg(logic [1:0] a);
    logic [31:0] v = '0;
    case (a)
      2'd0: v = m_dlog[31:0];
      2'd1: v = m_dlog[63:32];
      2'd2: begin v[18] = m_corr; v[17] = m_apar; v[16] = m_dpar; end
      default: begin v[0] = m_valid; v[1] = m_asts; v[2] = m_dsts; end
    endcase
    return v;
  endfunction

  task automatic rd_chk(string req, logic [1:0] a);
    reg_rd = 1; reg_addr = a;
    tick();
    chk(req, reg_rdata, exp_reg(a));
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick();
  endtask

  task automatic derr(logic [63:0] d, logic wide, logic c);
    ev_data_err = 1; ev_data_val = d; ev_data_wide = wide; ev_data_corr = c;
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    idle();
    por_n = 0; rst_n = 0;
    model_zero();
    repeat (3) @(negedge clk);
    por_n = 1; rst_n = 1;
    chk("R11 rdata after reset", reg_rdata, 32'h0);
    for (int a = 0; a < 4; a++) rd_chk("R11 reset value", 2'(a));

    // R1/R2/R5: wide correctable load
    derr(64'hDEAD_BEEF_1234_5678, 1, 1); tick();
    rd_chk("R1 low slice", 0);
    rd_chk("R2 wide high slice", 1);
    rd_chk("R5 corr flag", 2);
    rd_chk("R1 valid set", 3);
    // R3: frozen
    derr(64'h1111_2222_3333_4444, 1, 0); tick();
    rd_chk("R3 frozen low", 0);
    rd_chk("R3 frozen flag", 2);
    // R4: writing 0 has no effect
    wr(3, 32'h0); rd_chk("R4 zero write ignored", 3);
    // R9: writes to log registers ignored
    wr(0, 32'hFFFF_FFFF); wr(2, 32'hFFFF_FFFF); wr(3, 32'hFFFF_FFF8);
    rd_chk("R9 data write ignored", 0);
    rd_chk("R9 misc reserved", 2);
    rd_chk("R9 ctrl reserved", 3);
    // R4: clear then R2 narrow load keeps upper half
    wr(3, 32'h1); rd_chk("R4 valid cleared", 3);
    derr(64'hAAAA_AAAA_0BAD_F00D, 0, 0); tick();
    rd_chk("R2 narrow low", 0);
    rd_chk("R2 narrow high kept", 1);
    rd_chk("R5 uncorrectable flag", 2);
    // R10: clear and event together
    reg_wr = 1; reg_addr = 3; reg_wdata = 32'h1;
    derr(64'h5555_5555_6666_6666, 1, 1); tick();
    rd_chk("R10 clear wins", 3);
    derr(64'h5555_5555_6666_6666, 1, 1); tick();
    rd_chk("R10 next event logged", 0);
    // R6/R7/R8
    ev_attr_err = 1; ev_attr_par = 1; ev_addr_err = 1; ev_addr_dac = 0; ev_addr_hi_par = 1; tick();
    rd_chk("R7 single cycle forced zero", 2);
    rd_chk("R6 status bits", 3);
    ev_attr_err = 1; ev_attr_par = 0; tick();
    rd_chk("R8 first attr kept", 2);
    wr(3, 32'h6);
    rd_chk("R8 cleared", 2);
    ev_addr_err = 1; ev_addr_dac = 1; ev_addr_hi_par = 1; tick();
    rd_chk("R7 dual cycle parity", 2);
    // R10 for a status bit
    reg_wr = 1; reg_addr = 3; reg_wdata = 32'h4;
    ev_addr_err = 1; ev_addr_dac = 1; ev_addr_hi_par = 1; tick();
    rd_chk("R10 status clear wins", 3);
    // R11: functional reset keeps logs
    ev_attr_err = 1; ev_attr_par = 1; tick();
    rst_n = 0; @(negedge clk);
    chk("R11 rst_n clears rdata", reg_rdata, 32'h0);
    rst_n = 1;
    for (int a = 0; a < 4; a++) rd_chk("R11 logs survive rst_n", 2'(a));
    // R12: rdata holds when no read
    rd_chk("R12 read", 2);
    tick();
    chk("R12 hold", reg_rdata, exp_reg(2));

    // random phase
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 3) == 0)
        derr({$urandom, $urandom}, 1'($urandom), 1'($urandom));
      ev_attr_err = ($urandom_range(0, 4) == 0); ev_attr_par = 1'($urandom);
      ev_addr_err = ($urandom_range(0, 4) == 0); ev_addr_dac = 1'($urandom);
      ev_addr_hi_par = 1'($urandom);
      if ($urandom_range(0, 3) == 0) begin
        reg_wr = 1; reg_addr = 2'($urandom); reg_wdata = $urandom;
      end
      tick();
      if (i % 10 == 9) begin
        if (m_valid) begin
          rd_chk("R1 random low", 0);
          rd_chk("R2 random high", 1);
        end
        rd_chk("R5 random misc", 2);
        rd_chk("R10 random ctrl", 3);
      end
    end

    // R11: power-on reset clears sticky state
    por_n = 0; @(negedge clk); por_n = 1; model_zero();
    for (int a = 0; a < 4; a++) rd_chk("R11 por clears", 2'(a));
    summary();
  end
endmodule